// File: doc/BRIEF.md
# Two-Dimensional Decoded Read-Only Memory

This block is a 128-word by 1-bit read-only memory whose cells form a near-square array of 8 rows by 16 columns. No single 7-to-128 decoder is built. The three upper address bits go to a small one-hot row decoder. The selected row drives all 16 of its cells at once onto internal bit lines. A 16-way column multiplexer, steered by the four lower address bits, then picks the one output bit. The decoder logic therefore grows with the square root of the depth rather than with the depth itself.

Contents are fixed when the design is elaborated. They come from a 128-bit parameter in which bit `k` holds the word at address `k`. Inside the array each cell that stores a 1 pulls its bit line low. An inverter on every line turns it back to true polarity before the column multiplexer. A parameter chooses between two output modes. In the registered mode the output comes from a flop with a synchronous active-low reset. In the combinational mode the output follows the address with no clock in the path.

Top module: `rom2d_top`

## Requirements
- R1: For every address `a` in 0..127, the word read out equals bit `a` of the `CONTENTS` parameter.
- R2: The row decoder asserts exactly one of its 8 row lines, and that line has index `addr[6:4]`.
- R3: The selected row places its 16 words, addresses `addr[6:4]*16` through `addr[6:4]*16+15`, on the bit lines together. Each internal line is low when its cell holds a 1. After inversion, bit line `c` carries the word at address `addr[6:4]*16+c`.
- R4: The column multiplexer passes the bit line whose index equals `addr[3:0]`. Every one of the 16 columns of a row can be reached.
- R5: With `REGISTERED=1`, `data_out` shows the word for the address that was present at the previous rising clock edge. That is one clock of latency.
- R6: With `REGISTERED=0`, `data_out` shows the word for the address that is present now, in the same cycle, without waiting for a clock edge.
- R7: With `REGISTERED=1`, `data_out` is 0 at every edge where `rst_n` is sampled low, whatever the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset of the output register |
| addr | input | 7 | Word address; bits 6:4 pick the row, bits 3:0 pick the column |
| data_out | output | 1 | Stored bit for the address, registered or combinational as the parameter selects |

## Verification
The bound checker tests, on every cycle, the following:
- the row decoder is one-hot and points at `addr[6:4]`;
- the inverted bit lines carry the 16 words of the addressed row;
- the output matches the stored word, with one cycle of delay in registered mode and none in combinational mode.

Only the bench scenarios can show two further points. The first is that every one of the 128 addresses, including both edges of each row, returns the right value under sequential, descending and scrambled address orders. The second is that the reset value is held while the address keeps changing during reset.

// File: rtl/rom2d_pkg.sv
// Package rom2d_pkg
// Shared geometry helpers for the two-dimensional decoded ROM.
// Assumes the depth is a power of two split into row and column fields.
package rom2d_pkg;

    // Number of entries addressed by a field of the given width.
    function automatic int unsigned field_span(input int unsigned bits);
        return 32'd1 << bits;
    endfunction

endpackage

// File: rtl/rom2d_row_decoder.sv
// Module rom2d_row_decoder
// Turns the upper address field into one-hot row (word) lines.
// Assumes ROWS equals 2**ROW_BITS; exactly one output is high at any time.
module rom2d_row_decoder #(
    parameter int unsigned ROW_BITS = 3,
    parameter int unsigned ROWS     = 8
) (
    input  logic [ROW_BITS-1:0] row_idx,
    output logic [ROWS-1:0]     row_sel
);

    // One comparator per row line.
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        assign row_sel[r] = (row_idx == r[ROW_BITS-1:0]);
    end

endmodule

// File: rtl/rom2d_cell_array.sv
// Module rom2d_cell_array
// Cell matrix of ROWS x COLS. A cell that stores a 1 pulls its column line
// low when its row is selected; unselected rows leave the lines high.
// Assumes row_sel is one-hot and CONTENTS bit index equals word address.
module rom2d_cell_array #(
    parameter int unsigned ROWS     = 8,
    parameter int unsigned COLS     = 16,
    parameter logic [ROWS*COLS-1:0] CONTENTS = '0
) (
    input  logic [ROWS-1:0] row_sel,
    output logic [COLS-1:0] bit_lines_n
);

    logic [ROWS-1:0] pull [COLS];

    for (genvar c = 0; c < COLS; c++) begin : g_col
        for (genvar r = 0; r < ROWS; r++) begin : g_cell
            // A present transistor conducts only when its row line is high.
            if (CONTENTS[r*COLS + c]) begin : g_present
                assign pull[c][r] = row_sel[r];
            end else begin : g_absent
                assign pull[c][r] = 1'b0;
            end
        end
        // Wired pull-down: the line is low if any cell on it conducts.
        assign bit_lines_n[c] = ~(|pull[c]);
    end

endmodule

// File: rtl/rom2d_col_mux.sv
// Module rom2d_col_mux
// Selects one of COLS true-polarity bit lines by the lower address field.
// Assumes COLS equals 2**COL_BITS.
module rom2d_col_mux #(
    parameter int unsigned COL_BITS = 4,
    parameter int unsigned COLS     = 16
) (
    input  logic [COLS-1:0]     bit_lines,
    input  logic [COL_BITS-1:0] col_idx,
    output logic                bit_out
);

    // Plain indexed selection of the addressed column.
    always_comb begin
        bit_out = bit_lines[col_idx];
    end

endmodule

// File: rtl/rom2d_top.sv
// Module rom2d_top
// 128x1 read-only memory with two-dimensional decoding: a row decoder on the
// upper address bits, a parallel read of the row, and a column multiplexer on
// the lower bits. REGISTERED=1 adds an output flop with synchronous
// active-low reset; REGISTERED=0 leaves the read path purely combinational.
// Assumes ADDR_W = ROW_BITS + COL_BITS.
module rom2d_top #(
    parameter int unsigned ROW_BITS   = 3,
    parameter int unsigned COL_BITS   = 4,
    parameter bit          REGISTERED = 1'b1,
    parameter logic [(1<<(ROW_BITS+COL_BITS))-1:0] CONTENTS =
        128'hA5C3_0F96_1E2D_B478_6699_F00F_3C5A_81E7
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [ROW_BITS+COL_BITS-1:0] addr,
    output logic                         data_out
);

    import rom2d_pkg::*;

    localparam int unsigned ADDR_W = ROW_BITS + COL_BITS;
    localparam int unsigned ROWS   = field_span(ROW_BITS);
    localparam int unsigned COLS   = field_span(COL_BITS);

    logic [ROWS-1:0] row_sel;
    logic [COLS-1:0] bit_lines_n;
    logic [COLS-1:0] bit_lines;
    logic            read_bit;

    rom2d_row_decoder #(.ROW_BITS(ROW_BITS), .ROWS(ROWS)) u_rowdec (
        .row_idx (addr[ADDR_W-1:COL_BITS]),
        .row_sel (row_sel)
    );

    rom2d_cell_array #(.ROWS(ROWS), .COLS(COLS), .CONTENTS(CONTENTS)) u_array (
        .row_sel     (row_sel),
        .bit_lines_n (bit_lines_n)
    );

    // Sense inverters restore true polarity on every bit line.
    for (genvar c = 0; c < COLS; c++) begin : g_sense
        assign bit_lines[c] = ~bit_lines_n[c];
    end

    rom2d_col_mux #(.COL_BITS(COL_BITS), .COLS(COLS)) u_colmux (
        .bit_lines (bit_lines),
        .col_idx   (addr[COL_BITS-1:0]),
        .bit_out   (read_bit)
    );

    if (REGISTERED) begin : g_reg_out
        logic data_q;
        // Output flop: capture the read bit, clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) data_q <= 1'b0;
            else        data_q <= read_bit;
        end
        assign data_out = data_q;
    end else begin : g_comb_out
        assign data_out = read_bit;
    end

endmodule

// File: rtl/rom2d_chk.sv
// Module rom2d_chk
// Checker bound to rom2d_top: decoder shape, bit-line contents and the
// timing of the output in both modes.
// Assumes it sees the top's internal row lines and active-low bit lines.
module rom2d_chk #(
    parameter int unsigned ROW_BITS   = 3,
    parameter int unsigned COL_BITS   = 4,
    parameter bit          REGISTERED = 1'b1,
    parameter logic [(1<<(ROW_BITS+COL_BITS))-1:0] CONTENTS = '0
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic [ROW_BITS+COL_BITS-1:0]      addr,
    input logic [(1<<ROW_BITS)-1:0]          row_sel,
    input logic [(1<<COL_BITS)-1:0]          bit_lines_n,
    input logic                              data_out
);

    localparam int unsigned ADDR_W = ROW_BITS + COL_BITS;
    localparam int unsigned COLS   = 1 << COL_BITS;

    // R2
    row_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(row_sel) == 1);

    // R2
    row_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        row_sel[addr[ADDR_W-1:COL_BITS]] == 1'b1);

    // R3
    row_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (~bit_lines_n) == CONTENTS[{addr[ADDR_W-1:COL_BITS], {COL_BITS{1'b0}}} +: COLS]);

    if (REGISTERED) begin : g_reg
        // R5
        reg_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> data_out == CONTENTS[$past(addr)]);
    end else begin : g_comb
        // R6
        comb_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            data_out == CONTENTS[addr]);
    end

endmodule

bind rom2d_top rom2d_chk #(
    .ROW_BITS   (ROW_BITS),
    .COL_BITS   (COL_BITS),
    .REGISTERED (REGISTERED),
    .CONTENTS   (CONTENTS)
) u_rom2d_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr        (addr),
    .row_sel     (row_sel),
    .bit_lines_n (bit_lines_n),
    .data_out    (data_out)
);

// File: tb/test_rom2d_top.sv
// Bench for rom2d_top: a registered instance and a combinational one share
// the address. A behavioural model (expected-value queue) checks both outputs
// on every clock.
module test_rom2d_top;

    localparam logic [127:0] IMG = 128'h3C96_E01B_7FA2_58D4_0C6B_9E31_F705_A4C8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] addr = '0;
    logic       dout_reg;
    logic       dout_comb;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    rom2d_top #(.REGISTERED(1'b1), .CONTENTS(IMG)) i_rom2d_top (
        .clk (clk), .rst_n (rst_n), .addr (addr), .data_out (dout_reg)
    );

    rom2d_top #(.REGISTERED(1'b0), .CONTENTS(IMG)) i_rom2d_top_comb (
        .clk (clk), .rst_n (rst_n), .addr (addr), .data_out (dout_comb)
    );

    // Model: words captured at each rising edge outside reset.
    bit exp_q[$];

    task automatic check(input string req, input bit act, input bit exp, input int a);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s addr=%0d actual=%0b expected=%0b", req, a, act, exp);
        end
    endtask

    // Drive one address for one cycle and check both outputs.
    task automatic step(input int a, input string req);
        @(negedge clk);
        addr = a[6:0];
        #0.5;
        // R6: combinational copy follows the address in the same cycle
        check({req, "/R6"}, dout_comb, IMG[a], a);
        @(posedge clk);
        exp_q.push_back(IMG[a]);
        @(negedge clk);
        // R5: registered copy shows the word from the previous edge
        check({req, "/R5"}, dout_reg, exp_q.pop_front(), a);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int x;
        // R7: reset holds the registered output at 0 while the address moves
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            addr = 7'(i * 21 + 3);
            @(negedge clk);
            check("R7", dout_reg, 1'b0, int'(addr));
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R1: ascending sweep of every address
        for (int a = 0; a < 128; a++) step(a, "R1");
        // R4: descending sweep reaches every column in every row
        for (int a = 127; a >= 0; a--) step(a, "R4");
        // R3: row edges, first and last word of each row back to back
        for (int r = 0; r < 8; r++) begin
            step(r * 16, "R3");
            step(r * 16 + 15, "R3");
            step(((r + 5) % 8) * 16 + 7, "R3");
        end
        // R2: scrambled order jumping between rows
        x = 7'h5b;
        for (int i = 0; i < 200; i++) begin
            x = ((x << 1) | (((x >> 6) ^ (x >> 5)) & 1)) & 7'h7f;
            step(x, "R2");
        end

        // R7: reset asserted again mid-run clears the registered output
        @(negedge clk);
        rst_n = 1'b0;
        addr  = 7'd0;
        @(negedge clk);
        check("R7", dout_reg, 1'b0, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule